// File: doc/BRIEF.md
# Five-Channel Capture/PWM Timer with Infrared Carrier Gating

This block is a 16-bit general-purpose timer for a microcontroller subsystem. A main counter, stepped by a selectable prescaler, counts in modulo fashion from zero up to a programmable period. Five channels share this counter. Each channel works either as a PWM output, driven by its own compare value, or as an input capture that stores the counter value when a chosen edge appears on its pin. An 8-bit carrier timer sits beside it. It has its own prescaler, period and compare, and it produces a carrier waveform.

In infrared mode the main counter advances once per carrier period instead of once per prescaled clock. The PWM output of channel 1 then acts as a burst gate. The modulated output is the gate ANDed with the carrier and passed through one register. Software reaches everything through a simple register port: writes take effect on the clock edge and reads return data combinationally. The block has no streaming data path, so every pin is a plain control or status signal. Interrupt flags are held as levels until software clears them by writing ones.

Top module: `capture_pwm_timer`

## Requirements
- R1: After reset the counter is stopped at 0, the period reads 0xFFFF, all compares read 0, every channel is in PWM mode (channel output enables all high), all flags read 0 and `ir_out` is low.
- R2: Address 0x0 is control: bit 0 runs the counter and bits 2:1 pick the prescale divisor (0→1, 1→8, 2→32, 3→128). Address 0x1 is the period. While running, the counter steps 0..period, then wraps to 0 and sets overflow flag bit 0 at address 0x8. Two wraps are therefore (period+1)·divisor cycles apart.
- R3: Channel i's compare sits at address 0x2+i. In PWM mode `ch_oe[i]` is high and `ch_out[i]` is high exactly while counter < compare. A compare of 0 gives constant low; a compare above the period gives constant high.
- R4: Compare and period writes made while the counter runs take effect only at the next wrap. Until then a read of the channel address returns the previous compare. While the counter is stopped, writes take effect on the following cycle.
- R5: Address 0x7 holds 3 mode bits per channel at bit 3i. Bit 3i set selects capture. Bits 3i+2:3i+1 select the edge: 01 rising, 10 falling, 11 both, 00 none. A selected edge copies the counter into the channel register, which is then read at 0x2+i, and sets flag bit i+1. An edge that is not selected changes nothing. In capture mode `ch_oe[i]` and `ch_out[i]` are low.
- R6: A pin is synchronised by two flops, and a new level counts as an edge only after it has been sampled on two consecutive cycles. A one-cycle pulse is ignored.
- R7: Writing ones to address 0x8 clears the matching flags. A flag that is set in the same cycle as its clear stays set. `irq_ovf` mirrors bit 0 and `irq_cap[i]` mirrors bit i+1.
- R8: Control bit 3 selects infrared mode. In this mode the counter advances on carrier wraps, and `ir_out` is the registered AND of channel 1's PWM output and the carrier output. With bit 3 clear, `ir_out` is low.
- R9: The carrier timer has control at address 0x9 (bit 0 run, bits 2:1 divisor as in R2), period at 0xA and compare at 0xB. Its output is high while carrier count < carrier compare. Its period and compare obey the rule of R4 against its own wrap.
- R10: A write to address 0xC loads the main counter directly, taking priority over counting. A read of 0xC returns the counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| ch_in | input | 5 | Channel input pins |
| ch_out | output | 5 | Channel PWM outputs |
| ch_oe | output | 5 | Channel output enables |
| ir_out | output | 1 | Modulated infrared output |
| irq_ovf | output | 1 | Counter overflow flag |
| irq_cap | output | 5 | Channel capture flags |

## Verification
A capture event and a software clear of the same channel's flag can land on the same clock edge. The bench provokes this by raising a pin and then issuing the clearing write exactly three cycles later. That is the edge on which the synchroniser and the two-sample filter accept the new level. The check passes only if the flag still reads set afterwards and the channel register holds the counter value that was loaded beforehand.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  localparam int PRE_W = 7;

  localparam logic [1:0] EDGE_NONE = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

  // divisor minus one for a 2-bit prescale select: 1, 8, 32, 128
  function automatic logic [PRE_W-1:0] pre_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    pre_mask = PRE_W'(0);
      2'd1:    pre_mask = PRE_W'(7);
      2'd2:    pre_mask = PRE_W'(31);
      default: pre_mask = PRE_W'(127);
    endcase
  endfunction
endpackage

// File: rtl/cpt_prescaler.sv
module cpt_prescaler
  import cpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pc_q;
  logic [PRE_W-1:0] mask;

  assign mask = pre_mask(sel);
  assign tick = run && ((pc_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)            pc_q <= '0;
    else if (!run || tick) pc_q <= '0;
    else                   pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/cpt_carrier.sv
module cpt_carrier #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [1:0]   sel,
  input  logic         per_we,
  input  logic         cmp_we,
  input  logic [W-1:0] wdata,
  output logic         pwm,
  output logic         wrap,
  output logic [W-1:0] per_q,
  output logic [W-1:0] cmp_q
);
  logic         tick;
  logic [W-1:0] cnt_q, per_sh, cmp_sh;
  logic         load;

  cpt_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sel  (sel),
    .tick (tick)
  );

  assign wrap = tick && (cnt_q == per_q);
  assign load = !run || wrap;
  assign pwm  = run && (cnt_q < cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_sh <= '1;
      cmp_sh <= '0;
      per_q  <= '1;
      cmp_q  <= '0;
    end else begin
      if (per_we) per_sh <= wdata;
      if (cmp_we) cmp_sh <= wdata;
      if (load) begin
        per_q <= per_sh;
        cmp_q <= cmp_sh;
      end
      if (!run)      cnt_q <= '0;
      else if (wrap) cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  // carrier count never passes its active period (shadow rule keeps them in step)
  p_carrier_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_q);
endmodule

// File: rtl/cpt_channel.sv
module cpt_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         load,
  input  logic         cmp_we,
  input  logic [W-1:0] wdata,
  input  logic         cap_mode,
  input  logic [1:0]   edge_sel,
  input  logic         pin,
  input  logic         flag_clr,
  output logic         pwm_out,
  output logic         oe,
  output logic         flag,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] cmp_sh, cmp_act, cap_q;
  logic         s1_q, s2_q, s2d_q, filt_q;
  logic         acc_rise, acc_fall, hit;

  assign acc_rise = s2_q && s2d_q && !filt_q;
  assign acc_fall = !s2_q && !s2d_q && filt_q;
  assign hit      = cap_mode && ((acc_rise && edge_sel[0]) || (acc_fall && edge_sel[1]));

  assign oe      = !cap_mode;
  assign pwm_out = !cap_mode && (cnt < cmp_act);
  assign rd_val  = cap_mode ? cap_q : cmp_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_sh  <= '0;
      cmp_act <= '0;
      cap_q   <= '0;
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      s2d_q   <= 1'b0;
      filt_q  <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (cmp_we) cmp_sh <= wdata;
      if (load)   cmp_act <= cmp_sh;
      s1_q  <= pin;
      s2_q  <= s1_q;
      s2d_q <= s2_q;
      if (acc_rise)      filt_q <= 1'b1;
      else if (acc_fall) filt_q <= 1'b0;
      if (hit) cap_q <= cnt;
      flag <= hit || (flag && !flag_clr);
    end
  end

  // R6: filtered level rises only after two agreeing samples
  p_filter_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_q) |-> ($past(s2_q) && $past(s2d_q)));
  // R4: active compare moves only on a load slot
  p_cmp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cmp_act));
  // R3: zero compare keeps the output low
  p_pwm_zero_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act == '0) |-> !pwm_out);
endmodule

// File: rtl/capture_pwm_timer.sv
module capture_pwm_timer
  import cpt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int CAR_W   = 8,
  parameter int NUM_CH  = 5,
  parameter int AW      = 4,
  parameter int GATE_CH = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic [NUM_CH-1:0] ch_in,
  output logic [NUM_CH-1:0] ch_out,
  output logic [NUM_CH-1:0] ch_oe,
  output logic              ir_out,
  output logic              irq_ovf,
  output logic [NUM_CH-1:0] irq_cap
);
  localparam int            DW      = CNT_W;
  localparam int            MODE_W  = 3 * NUM_CH;
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_PER   = AW'(1);
  localparam int            A_CH0   = 2;
  localparam logic [AW-1:0] A_MODE  = AW'(A_CH0 + NUM_CH);
  localparam logic [AW-1:0] A_FLAG  = AW'(A_CH0 + NUM_CH + 1);
  localparam logic [AW-1:0] A_CCTRL = AW'(A_CH0 + NUM_CH + 2);
  localparam logic [AW-1:0] A_CPER  = AW'(A_CH0 + NUM_CH + 3);
  localparam logic [AW-1:0] A_CCMP  = AW'(A_CH0 + NUM_CH + 4);
  localparam logic [AW-1:0] A_COUNT = AW'(A_CH0 + NUM_CH + 5);

  logic              run_q, ir_q, c_run_q;
  logic [1:0]        sel_q, c_sel_q;
  logic [CNT_W-1:0]  per_sh, per_act, cnt_q;
  logic [MODE_W-1:0] mode_q;
  logic              ovf_q, ir_out_q;
  logic              pre_tick, step, wrap, load;
  logic              c_pwm, c_wrap;
  logic [CAR_W-1:0]  c_per, c_cmp;
  logic              cnt_wr, flag_wr;
  logic [NUM_CH-1:0] ch_pwm, cap_flag;
  logic [CNT_W-1:0]  ch_rd [NUM_CH];

  assign cnt_wr  = reg_we && (reg_addr == A_COUNT);
  assign flag_wr = reg_we && (reg_addr == A_FLAG);

  cpt_prescaler u_main_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_q && !ir_q),
    .sel  (sel_q),
    .tick (pre_tick)
  );

  cpt_carrier #(.W(CAR_W)) u_carrier (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (c_run_q),
    .sel   (c_sel_q),
    .per_we(reg_we && (reg_addr == A_CPER)),
    .cmp_we(reg_we && (reg_addr == A_CCMP)),
    .wdata (reg_wdata[CAR_W-1:0]),
    .pwm   (c_pwm),
    .wrap  (c_wrap),
    .per_q (c_per),
    .cmp_q (c_cmp)
  );

  // main counter steps on prescaled ticks, or on carrier wraps in IR mode
  assign step = run_q && (ir_q ? c_wrap : pre_tick);
  assign wrap = step && (cnt_q == per_act);
  assign load = !run_q || wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      ir_q     <= 1'b0;
      sel_q    <= 2'd0;
      c_run_q  <= 1'b0;
      c_sel_q  <= 2'd0;
      per_sh   <= '1;
      per_act  <= '1;
      cnt_q    <= '0;
      mode_q   <= '0;
      ovf_q    <= 1'b0;
      ir_out_q <= 1'b0;
    end else begin
      if (reg_we && (reg_addr == A_CTRL)) begin
        run_q <= reg_wdata[0];
        sel_q <= reg_wdata[2:1];
        ir_q  <= reg_wdata[3];
      end
      if (reg_we && (reg_addr == A_CCTRL)) begin
        c_run_q <= reg_wdata[0];
        c_sel_q <= reg_wdata[2:1];
      end
      if (reg_we && (reg_addr == A_PER))  per_sh <= reg_wdata;
      if (reg_we && (reg_addr == A_MODE)) mode_q <= reg_wdata[MODE_W-1:0];
      if (load) per_act <= per_sh;
      if (cnt_wr)    cnt_q <= reg_wdata;
      else if (wrap) cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
      ovf_q    <= wrap || (ovf_q && !(flag_wr && reg_wdata[0]));
      ir_out_q <= ir_q && ch_pwm[GATE_CH] && c_pwm;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    cpt_channel #(.W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt     (cnt_q),
      .load    (load),
      .cmp_we  (reg_we && (reg_addr == AW'(A_CH0 + i))),
      .wdata   (reg_wdata),
      .cap_mode(mode_q[3*i]),
      .edge_sel(mode_q[3*i+1 +: 2]),
      .pin     (ch_in[i]),
      .flag_clr(flag_wr && reg_wdata[i+1]),
      .pwm_out (ch_pwm[i]),
      .oe      (ch_oe[i]),
      .flag    (cap_flag[i]),
      .rd_val  (ch_rd[i])
    );
  end

  assign ch_out  = ch_pwm;
  assign ir_out  = ir_out_q;
  assign irq_ovf = ovf_q;
  assign irq_cap = cap_flag;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL)       reg_rdata = DW'({ir_q, sel_q, run_q});
    else if (reg_addr == A_PER)   reg_rdata = per_act;
    else if (reg_addr == A_MODE)  reg_rdata = DW'(mode_q);
    else if (reg_addr == A_FLAG)  reg_rdata = DW'({cap_flag, ovf_q});
    else if (reg_addr == A_CCTRL) reg_rdata = DW'({c_sel_q, c_run_q});
    else if (reg_addr == A_CPER)  reg_rdata = DW'(c_per);
    else if (reg_addr == A_CCMP)  reg_rdata = DW'(c_cmp);
    else if (reg_addr == A_COUNT) reg_rdata = cnt_q;
    else begin
      for (int i = 0; i < NUM_CH; i++)
        if (reg_addr == AW'(A_CH0 + i)) reg_rdata = ch_rd[i];
    end
  end

  // R2: a wrap returns the counter to zero unless software loads it
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !cnt_wr) |=> (cnt_q == '0));
  // R8: outside IR mode the modulated output stays low
  p_ir_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_q |=> !ir_out);
endmodule

// File: tb/capture_pwm_timer_bench.sv
`timescale 1ns/1ps
module capture_pwm_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [4:0]  ch_in = '0;
  logic [4:0]  ch_out, ch_oe, irq_cap;
  logic        ir_out, irq_ovf;

  localparam int CTRL = 0, PER = 1, CH0 = 2, MODE = 7, FLAG = 8;
  localparam int CCTRL = 9, CPER = 10, CCMP = 11, COUNT = 12;

  capture_pwm_timer u_capture_pwm_timer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_in(ch_in),
    .ch_out(ch_out), .ch_oe(ch_oe), .ir_out(ir_out), .irq_ovf(irq_ovf),
    .irq_cap(irq_cap)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard queues
  string exp_tag[$];
  int    exp_val[$];
  int    act_val[$];
  int    compared = 0;
  int    mismatched = 0;
  bit    done = 1'b0;

  always @(negedge clk) begin
    while (exp_val.size() > 0 && act_val.size() > 0) begin
      automatic string t = exp_tag.pop_front();
      automatic int    e = exp_val.pop_front();
      automatic int    a = act_val.pop_front();
      compared++;
      if (a != e) begin
        mismatched++;
        $display("FAIL %s: actual %0d expected %0d", t, a, e);
      end
    end
  end

  task automatic chk(input string tag, input int actual, input int expected);
    exp_tag.push_back(tag);
    exp_val.push_back(expected);
    act_val.push_back(actual);
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = 4'(a);
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // which < 0 counts ir_out
  task automatic count_high(input int which, input int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      if (which < 0) h += int'(ir_out);
      else           h += int'(ch_out[which]);
      @(negedge clk);
    end
  endtask

  task automatic wait_ovf();
    int v;
    rd(FLAG, v);
    while ((v & 1) == 0) begin
      idle(1);
      rd(FLAG, v);
    end
  endtask

  task automatic ovf_interval(output int d);
    int t1;
    wr(FLAG, 1);
    wait_ovf();
    t1 = cyc;
    wr(FLAG, 1);
    wait_ovf();
    d = cyc - t1;
  endtask

  task automatic setup_main(input int per);
    wr(CTRL, 0);
    wr(COUNT, 0);
    wr(PER, per);
    idle(2);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int v;
    int h;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(CTRL, v);  chk("R1 control", v, 0);
    rd(PER, v);   chk("R1 period", v, 65535);
    rd(CH0, v);   chk("R1 compare", v, 0);
    rd(FLAG, v);  chk("R1 flags", v, 0);
    chk("R1 oe", int'(ch_oe), 31);
    chk("R1 ir_out", int'(ir_out), 0);

    // R3 duty cycles, period 9, divide by 1
    setup_main(9);
    wr(CH0, 3); wr(CH0 + 2, 0); wr(CH0 + 3, 12); wr(CH0 + 4, 10);
    idle(2);
    wr(CTRL, 1);
    idle(3);
    count_high(0, 10, h); chk("R3 duty 3/10", h, 3);
    count_high(2, 10, h); chk("R3 compare 0 low", h, 0);
    count_high(3, 10, h); chk("R3 compare above period high", h, 10);
    count_high(4, 10, h); chk("R3 compare period+1 high", h, 10);
    rd(COUNT, v); chk("R2 count within period", int'(v <= 9), 1);

    // R4 shadowed compare
    setup_main(999);
    wr(CTRL, 1);
    wr(FLAG, 1);
    wr(CH0, 500);
    idle(1);
    rd(CH0, v); chk("R4 old compare before wrap", v, 3);
    wait_ovf();
    idle(2);
    rd(CH0, v); chk("R4 new compare after wrap", v, 500);
    rd(PER, v); chk("R4 period applied while stopped", v, 999);

    // R2 prescaler intervals
    setup_main(9);
    wr(CTRL, 1 | (1 << 1));
    ovf_interval(h); chk("R2 divide 8 interval", h, 80);
    setup_main(1);
    wr(CTRL, 1 | (2 << 1));
    ovf_interval(h); chk("R2 divide 32 interval", h, 64);
    setup_main(4);
    wr(CTRL, 1 | (3 << 1));
    ovf_interval(h); chk("R2 divide 128 interval", h, 640);
    chk("R7 irq_ovf mirrors flag", int'(irq_ovf), 1);

    // R5 capture on a stopped counter, R10 counter load
    wr(CTRL, 0);
    wr(COUNT, 1234);
    idle(1);
    rd(COUNT, v); chk("R10 counter load", v, 1234);
    wr(MODE, (1 << 6) | (1 << 7) | (1 << 9) | (3 << 10));
    wr(FLAG, 63);
    idle(1);
    ch_in[2] = 1'b1;
    idle(6);
    rd(FLAG, v);  chk("R5 rise flag", v, 8);
    rd(CH0 + 2, v); chk("R5 rise captured", v, 1234);
    chk("R5 capture oe low", int'(ch_oe[2]), 0);
    chk("R5 capture out low", int'(ch_out[2]), 0);
    chk("R7 irq_cap mirrors flag", int'(irq_cap), 4);
    wr(FLAG, 8);
    rd(FLAG, v);  chk("R7 clear", v, 0);

    wr(COUNT, 77);
    ch_in[2] = 1'b0;
    idle(6);
    rd(FLAG, v);  chk("R5 falling edge ignored flag", v, 0);
    rd(CH0 + 2, v); chk("R5 falling edge ignored value", v, 1234);

    // R6 glitch filter
    ch_in[2] = 1'b1;
    idle(1);
    ch_in[2] = 1'b0;
    idle(6);
    rd(FLAG, v);  chk("R6 one-cycle pulse ignored", v, 0);
    wr(COUNT, 88);
    ch_in[2] = 1'b1;
    idle(2);
    ch_in[2] = 1'b0;
    idle(6);
    rd(FLAG, v);  chk("R6 two-cycle pulse accepted", v, 8);
    rd(CH0 + 2, v); chk("R6 two-cycle pulse value", v, 88);

    // R5 both edges on channel 3
    wr(FLAG, 63);
    wr(COUNT, 55);
    ch_in[3] = 1'b1;
    idle(6);
    rd(CH0 + 3, v); chk("R5 both-edge rise value", v, 55);
    wr(FLAG, 16);
    wr(COUNT, 66);
    ch_in[3] = 1'b0;
    idle(6);
    rd(CH0 + 3, v); chk("R5 both-edge fall value", v, 66);
    rd(FLAG, v);  chk("R5 both-edge fall flag", v, 16);

    // R7 capture and clear on the same edge
    wr(FLAG, 63);
    wr(COUNT, 300);
    ch_in[2] = 1'b1;
    idle(3);
    wr(FLAG, 8);
    idle(2);
    rd(FLAG, v);  chk("R7 set wins over clear", v, 8);
    rd(CH0 + 2, v); chk("R7 collision captured value", v, 300);

    // R8 and R9 infrared gating
    setup_main(4);
    wr(CH0 + 1, 2);
    wr(CPER, 3);
    wr(CCMP, 2);
    wr(CCTRL, 1);
    idle(2);
    rd(CPER, v); chk("R9 carrier period", v, 3);
    wr(CTRL, 1 | (1 << 3));
    idle(30);
    count_high(-1, 20, h); chk("R8 burst high cycles 2x2", h, 4);
    wr(CCMP, 1);
    wr(CH0 + 1, 3);
    idle(45);
    count_high(-1, 20, h); chk("R8 R9 burst high cycles 3x1", h, 3);
    wr(CTRL, 1);
    idle(3);
    count_high(-1, 20, h); chk("R8 ir_out low outside IR mode", h, 0);

    idle(3);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule